// File: doc/BRIEF.md
# AHB Master Burst Sequencer

This block turns one DMA request of N 32-bit words into a series of AHB master address phases. A four-bit code picks the burst type. A one-bit tail switch decides how words that cannot fill a whole fixed-length burst are issued: either as one undefined-length incrementing burst, or as a chain of single transfers. A start strobe loads the word address, the word count, the code and the tail switch. The block then drives HTRANS, HBURST and HADDR until every word has been accepted, and pulses done.

The block moves no data and only controls the address phase. HREADY gates every step: a beat counts as accepted in a cycle where HTRANS is not IDLE and HREADY is high. Error responses and address-boundary splitting are left to the logic around it.

Top module: `ahb_burst_seq`

## Requirements
- R1: After reset, htrans is IDLE (2'b00), done is 0 and haddr is 0.
- R2: Burst code 4'b0000 issues every word as SINGLE (hburst 3'b000) with htrans NONSEQ (2'b10).
- R3: Burst code 4'b0001 issues the whole transfer as one INCR burst (hburst 3'b001): NONSEQ on the first beat, SEQ (2'b11) on every later beat.
- R4: Codes 4'b0011, 4'b0101 and 4'b0111 issue whole bursts of 4, 8 and 16 beats with hburst 3'b011, 3'b101 and 3'b111. Each burst opens with NONSEQ and continues with SEQ.
- R5: With the tail switch at 0, the words left after the last whole fixed burst go out as one INCR burst (NONSEQ, then SEQ).
- R6: With the tail switch at 1, those leftover words go out as separate SINGLE NONSEQ transfers.
- R7: haddr starts at the loaded address and steps by 4 for each accepted beat. While HREADY is low, haddr, htrans and hburst hold their values.
- R8: done is high for exactly one cycle, the cycle after the last beat is accepted, and htrans is IDLE in that cycle. A start with a word count of 0 pulses done in the next cycle and issues no beat.
- R9: A start strobe while a transfer is in progress has no effect.
- R10: Any reserved code (every value not listed in R2 to R4) is treated as SINGLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Loads a new transfer when the block is idle |
| start_addr | input | AW | Address of the first word |
| word_cnt | input | CW | Number of 32-bit words |
| burst_code | input | 4 | Burst-type code |
| tail_single | input | 1 | 1: tail words as SINGLE, 0: tail as one INCR |
| hready | input | 1 | Bus ready; a beat is accepted when this is high |
| htrans | output | 2 | Transfer type (IDLE/NONSEQ/SEQ) |
| hburst | output | 3 | Burst type |
| haddr | output | AW | Beat address |
| done | output | 1 | One-cycle pulse after the last accepted beat |

## Verification
The assertions assume that HREADY is a clean 0/1 level. They also assume that start_addr is word aligned, so each step of 4 stays inside the address width. The bench keeps to word-aligned addresses and short transfers. It drives HREADY from a pseudo-random sequence, so stalls land on first beats, middle beats and last beats alike. The bench applies a second start strobe in the middle of a transfer only to check that it is ignored.

// File: rtl/ahb_burst_seq.sv
module ahb_burst_seq #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] word_cnt,
  input  logic [3:0]    burst_code,
  input  logic          tail_single,
  input  logic          hready,
  output logic [1:0]    htrans,
  output logic [2:0]    hburst,
  output logic [AW-1:0] haddr,
  output logic          done
);
  localparam logic [1:0] T_IDLE = 2'b00, T_NSEQ = 2'b10, T_SEQ = 2'b11;
  localparam logic [2:0] B_SGL = 3'b000, B_INC = 3'b001;

  logic          active, first, tail_q;
  logic [3:0]    code_q;
  logic [CW-1:0] rem, left;
  logic [2:0]    hb;
  logic [AW-1:0] addr;

  function automatic logic [CW+2:0] pick(input logic [CW-1:0] n, input logic [3:0] code,
                                         input logic tl);
    logic [CW-1:0] fl;
    logic [2:0]    b;
    fl = '0;
    b  = B_SGL;
    case (code)
      4'b0001: return {B_INC, n};
      4'b0011: begin fl = CW'(4);  b = 3'b011; end
      4'b0101: begin fl = CW'(8);  b = 3'b101; end
      4'b0111: begin fl = CW'(16); b = 3'b111; end
      default: return {B_SGL, CW'(1)};
    endcase
    if (n >= fl) return {b, fl};
    if (tl)      return {B_SGL, CW'(1)};
    return {B_INC, n};
  endfunction

  assign htrans = !active ? T_IDLE : (first ? T_NSEQ : T_SEQ);
  assign hburst = hb;
  assign haddr  = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      first  <= 1'b0;
      tail_q <= 1'b0;
      code_q <= 4'b0000;
      rem    <= '0;
      left   <= '0;
      hb     <= B_SGL;
      addr   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          if (word_cnt == '0) begin
            done <= 1'b1;
          end else begin
            active     <= 1'b1;
            first      <= 1'b1;
            addr       <= start_addr;
            rem        <= word_cnt;
            code_q     <= burst_code;
            tail_q     <= tail_single;
            {hb, left} <= pick(word_cnt, burst_code, tail_single);
          end
        end
      end else if (hready) begin
        addr <= addr + AW'(4);
        rem  <= rem - CW'(1);
        if (left == CW'(1)) begin
          first <= 1'b1;
          if (rem == CW'(1)) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            {hb, left} <= pick(rem - CW'(1), code_q, tail_q);
          end
        end else begin
          left  <= left - CW'(1);
          first <= 1'b0;
        end
      end
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != T_IDLE && !hready) |=> ($stable(haddr) && $stable(htrans) && $stable(hburst)));

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != T_IDLE && hready) |=> (htrans == T_IDLE || haddr == $past(haddr) + AW'(4)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> htrans == T_IDLE);

  // R2
  single_nonseq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != T_IDLE && hburst == B_SGL) |-> htrans == T_NSEQ);

  // R4
  seq_same_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != T_IDLE && hready) |=> (htrans != T_SEQ || hburst == $past(hburst)));
endmodule

// File: tb/tb_ahb_burst_seq.sv
module tb_ahb_burst_seq;
  localparam int CLK_P = 10;
  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          start = 1'b0, tail_single = 1'b0, hready = 1'b1;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] word_cnt = '0;
  logic [3:0]    burst_code = 4'b0000;
  logic [1:0]    htrans;
  logic [2:0]    hburst;
  logic [AW-1:0] haddr;
  logic          done;

  ahb_burst_seq #(.AW(AW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .word_cnt(word_cnt), .burst_code(burst_code), .tail_single(tail_single),
    .hready(hready), .htrans(htrans), .hburst(hburst), .haddr(haddr), .done(done));

  always #(CLK_P/2) clk = ~clk;

  int vectors = 0, errors = 0, done_seen = 0, cyc = 0;
  bit rnd_ready = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [36:0] expq[$];
  string       tagq[$];

  always @(negedge clk) begin
    lfsr   <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    hready <= rnd_ready ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      errors++;
      $display("FAIL watchdog: actual cycle %0d expected finish earlier", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && htrans != 2'b00 && hready) begin
      vectors++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R9: actual unexpected beat %h/%b/%b expected none", haddr, htrans, hburst);
      end else begin
        logic [36:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        if ({htrans, hburst, haddr} !== e) begin
          errors++;
          $display("FAIL %s: actual trans=%b burst=%b addr=%h expected trans=%b burst=%b addr=%h",
                   t, htrans, hburst, haddr, e[36:35], e[34:32], e[31:0]);
        end
      end
    end
    if (rst_n && done) begin
      done_seen++;
      vectors++;
      if (expq.size() != 0 || htrans != 2'b00) begin
        errors++;
        $display("FAIL R8: actual done with %0d beats left, htrans=%b expected 0 left, 00",
                 expq.size(), htrans);
      end
    end
  end

  task automatic push(input logic [1:0] t, input logic [2:0] b, input logic [AW-1:0] a,
                      input string tag);
    expq.push_back({t, b, a});
    tagq.push_back(tag);
  endtask

  task automatic run(input logic [AW-1:0] a, input int n, input logic [3:0] code,
                     input logic tl, input bit poke, input string tag);
    int L;
    logic [2:0] fb;
    int full;
    L = 0;
    fb = 3'b000;
    case (code)
      4'b0011: begin L = 4;  fb = 3'b011; end
      4'b0101: begin L = 8;  fb = 3'b101; end
      4'b0111: begin L = 16; fb = 3'b111; end
      default: L = 0;
    endcase
    full = (L == 0) ? 0 : (n / L) * L;
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] ad;
      ad = a + AW'(4 * i);
      if (code == 4'b0001)
        push(i == 0 ? 2'b10 : 2'b11, 3'b001, ad, tag);
      else if (L == 0)
        push(2'b10, 3'b000, ad, tag);
      else if (i < full)
        push((i % L) == 0 ? 2'b10 : 2'b11, fb, ad, tag);
      else if (tl)
        push(2'b10, 3'b000, ad, "R6");
      else
        push(i == full ? 2'b10 : 2'b11, 3'b001, ad, "R5");
    end
    done_seen = 0;
    @(negedge clk);
    start_addr = a; word_cnt = CW'(n); burst_code = code; tail_single = tl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 3000 && done_seen == 0; k++) begin
      if (poke && k == 2) begin
        start_addr = 32'h0BAD_0000; word_cnt = CW'(3); burst_code = 4'b0000; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
    vectors++;
    if (done_seen != 1 || expq.size() != 0) begin
      errors++;
      $display("FAIL R8 (%s): actual done count %0d, %0d beats missing expected 1, 0",
               tag, done_seen, expq.size());
    end
    expq.delete();
    tagq.delete();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    vectors++;
    if (htrans !== 2'b00 || done !== 1'b0 || haddr !== '0) begin
      errors++;
      $display("FAIL R1: actual htrans=%b done=%b haddr=%h expected 00 0 0", htrans, done, haddr);
    end
    rst_n = 1'b1;
    run(32'h0000_1000, 3,  4'b0000, 1'b0, 1'b0, "R2");
    run(32'h0000_2000, 7,  4'b0001, 1'b0, 1'b0, "R3");
    run(32'h0000_3000, 8,  4'b0101, 1'b0, 1'b0, "R4");
    run(32'h0000_4000, 10, 4'b0011, 1'b0, 1'b0, "R4");
    run(32'h0000_5000, 10, 4'b0011, 1'b1, 1'b0, "R4");
    run(32'h0000_6000, 37, 4'b0111, 1'b0, 1'b0, "R4");
    run(32'h0000_7000, 1,  4'b0011, 1'b0, 1'b0, "R5");
    run(32'h0000_8000, 3,  4'b0010, 1'b0, 1'b0, "R10");
    run(32'h0000_9000, 2,  4'b1111, 1'b1, 1'b0, "R10");
    run(32'h0000_A000, 0,  4'b0011, 1'b0, 1'b0, "R8");
    rnd_ready = 1'b1;
    run(32'h0001_0000, 21, 4'b0101, 1'b1, 1'b0, "R7");
    run(32'h0001_1000, 19, 4'b0111, 1'b0, 1'b0, "R7");
    run(32'h0001_2000, 9,  4'b0001, 1'b0, 1'b1, "R9");
    run(32'h0001_3000, 6,  4'b0011, 1'b1, 1'b1, "R9");
    rnd_ready = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule